// File: doc/BRIEF.md
# RTC Update Cycle and Periodic Interrupt Engine

This block is the timing heart of a real-time clock. It counts pulses of a 32768 Hz time base, which arrives as a one-cycle enable on the system clock. From these pulses it makes three things: a once-per-second update event, a window that flags an imminent update, and a periodic event at a programmable rate. It keeps the update flag and the periodic flag, and it combines them with their enables into an interrupt-request flag and an interrupt line.

Software writes an oscillator/divider control field, a rate code, two interrupt enables and a SET bit. Software clears the flags with a pulse that accompanies a status read. A calendar counter outside this block advances on the update tick this block emits. Holding the divider in reset freezes every timing chain. Releasing the hold puts the first update half a second later.

Top module: `rtc_tick_core`

## Requirements
- R1: During and right after reset, `flags_o`, `upd_tick_o`, `irq_o` and `uip_o` are all 0.
- R2: While the divider is not held, an update event occurs on every `TICK_HZ`-th counted time-base pulse. Each update event sets the update flag, `flags_o[4]`, in the cycle after the pulse.
- R3: `uip_o` is 1 while the clock runs and fewer than `UIP_TICKS` counted pulses remain before the next update. It drops to 0 once the update completes.
- R4: With `div_ctl_i[2:1]` = 2'b11 (divider held), no update event occurs, `uip_o` stays 0, and the periodic chain is stopped and cleared.
- R5: After a release from hold, the first update event occurs after exactly `TICK_HZ/2` counted pulses.
- R6: `upd_tick_o` is a one-cycle pulse, issued with an update event only when `set_mode_i` = 0 and `div_ctl_i` <= 3'd2. While SET is 1, update events still set the update flag.
- R7: With `pie_i` = 1, a nonzero rate code sets the periodic flag, `flags_o[6]`. Codes 1 and 2 do so every 128 and 64 pulses; a code c of 3 to 15 does so every 2^(c-1) pulses. Rate 0 or `pie_i` = 0 stops the chain and clears its count.
- R8: A change of `rate_i` restarts the periodic count from zero.
- R9: `flags_o[7]` = (update flag AND `uie_i`) OR (periodic flag AND `pie_i`). `irq_o` equals `flags_o[7]`, so enabling an interrupt while its flag is already set raises the line at once.
- R10: `flag_clr_i` clears both flags. When an event sets a flag in the same cycle as the clear, that flag ends up set. Bits 5 and 3:0 of `flags_o` are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tb_tick_i | input | 1 | One-cycle time-base pulse, nominally 32768 per second |
| div_ctl_i | input | 3 | Oscillator/divider control field |
| rate_i | input | 4 | Periodic rate code |
| pie_i | input | 1 | Periodic interrupt enable |
| uie_i | input | 1 | Update interrupt enable |
| set_mode_i | input | 1 | SET bit: freezes calendar advance |
| flag_clr_i | input | 1 | Flag clear pulse from a status read |
| upd_tick_o | output | 1 | Calendar advance pulse |
| uip_o | output | 1 | Update-in-progress indication |
| flags_o | output | 8 | Status image: bit 7 IRQF, bit 6 PF, bit 4 UF |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
Some properties are checked by assertions on every cycle. An advance pulse always coincides with a set update flag and never with the in-progress window. The pulse lasts one cycle. A held divider or an active SET bit blocks the pulse. A raised request flag always has a flag behind it.

Other behaviours can only be shown by the bench's scenarios. These are the exact half-second delay after release, the length of the in-progress window, the period for each rate code, the restart on a rate change, and the set-wins rule when a clear meets an event. The bench checks them against a cycle model driven by random tick gaps, enables, hold episodes and clears.

// File: rtl/rtc_tick_pkg.sv
package rtc_tick_pkg;
  localparam int unsigned RATE_W   = 4;
  localparam int unsigned PER_W    = 15;
  localparam int unsigned FLG_IRQF = 7;
  localparam int unsigned FLG_PF   = 6;
  localparam int unsigned FLG_UF   = 4;

  typedef struct packed {
    logic hold;
    logic run;
  } div_mode_t;

  function automatic div_mode_t decode_div(input logic [2:0] ctl, input logic set_mode);
    div_mode_t m;
    m.hold = (ctl[2:1] == 2'b11);
    m.run  = !set_mode && (ctl <= 3'd2);
    return m;
  endfunction

  // terminal count (period - 1) for a nonzero rate code
  function automatic logic [PER_W-1:0] rate_to_last(input logic [RATE_W-1:0] code);
    logic [PER_W-1:0] one;
    one = PER_W'(1);
    case (code)
      4'd1:    return PER_W'(127);
      4'd2:    return PER_W'(63);
      default: return (one << (code - 4'd1)) - one;
    endcase
  endfunction
endpackage

// File: rtl/rtc_sec_div.sv
module rtc_sec_div #(
  parameter int unsigned TICK_HZ   = 32768,
  parameter int unsigned UIP_TICKS = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tb_tick_i,
  input  logic hold_i,
  input  logic run_i,
  output logic upd_evt_o,
  output logic uip_o
);
  localparam int unsigned PH_W = $clog2(TICK_HZ);
  localparam logic [PH_W-1:0] PH_LAST  = PH_W'(TICK_HZ - 1);
  localparam logic [PH_W-1:0] PH_HALF  = PH_W'(TICK_HZ / 2);
  localparam logic [PH_W-1:0] PH_UIP   = PH_W'(TICK_HZ - UIP_TICKS);

  logic [PH_W-1:0] phase_q;

  assign upd_evt_o = tb_tick_i && !hold_i && (phase_q == PH_LAST);
  assign uip_o     = run_i && (phase_q >= PH_UIP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
    end else if (hold_i) begin
      phase_q <= PH_HALF;  // release lands half a second before update
    end else if (tb_tick_i) begin
      phase_q <= (phase_q == PH_LAST) ? '0 : phase_q + PH_W'(1);
    end
  end
endmodule

// File: rtl/rtc_per_div.sv
module rtc_per_div
  import rtc_tick_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tb_tick_i,
  input  logic              en_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic              per_evt_o
);
  logic [RATE_W-1:0] rate_q;
  logic [PER_W-1:0]  cnt_q;
  logic [PER_W-1:0]  last;
  logic              rate_chg;

  assign last      = rate_to_last(rate_i);
  assign rate_chg  = (rate_i != rate_q);
  assign per_evt_o = en_i && !rate_chg && tb_tick_i && (cnt_q == last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rate_q <= '0;
      cnt_q  <= '0;
    end else begin
      rate_q <= rate_i;
      if (!en_i || rate_chg) begin
        cnt_q <= '0;
      end else if (tb_tick_i) begin
        cnt_q <= (cnt_q == last) ? '0 : cnt_q + PER_W'(1);
      end
    end
  end
endmodule

// File: rtl/rtc_flag_unit.sv
module rtc_flag_unit
  import rtc_tick_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       upd_evt_i,
  input  logic       per_evt_i,
  input  logic       clr_i,
  input  logic       uie_i,
  input  logic       pie_i,
  output logic [7:0] flags_o,
  output logic       irq_o
);
  logic uf_q, pf_q, irqf;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      uf_q <= 1'b0;
      pf_q <= 1'b0;
    end else begin
      uf_q <= upd_evt_i | (uf_q & ~clr_i);
      pf_q <= per_evt_i | (pf_q & ~clr_i);
    end
  end

  assign irqf = (uf_q & uie_i) | (pf_q & pie_i);

  always_comb begin
    flags_o           = '0;
    flags_o[FLG_UF]   = uf_q;
    flags_o[FLG_PF]   = pf_q;
    flags_o[FLG_IRQF] = irqf;
  end

  assign irq_o = irqf;
endmodule

// File: rtl/rtc_tick_core.sv
module rtc_tick_core
  import rtc_tick_pkg::*;
#(
  parameter int unsigned TICK_HZ   = 32768,
  parameter int unsigned UIP_TICKS = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tb_tick_i,
  input  logic [2:0]        div_ctl_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic              pie_i,
  input  logic              uie_i,
  input  logic              set_mode_i,
  input  logic              flag_clr_i,
  output logic              upd_tick_o,
  output logic              uip_o,
  output logic [7:0]        flags_o,
  output logic              irq_o
);
  div_mode_t mode;
  logic      upd_evt, per_evt, per_en, upd_tick_q;

  assign mode   = decode_div(div_ctl_i, set_mode_i);
  assign per_en = pie_i && (rate_i != '0) && !mode.hold;

  rtc_sec_div #(
    .TICK_HZ  (TICK_HZ),
    .UIP_TICKS(UIP_TICKS)
  ) u_sec (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tb_tick_i(tb_tick_i),
    .hold_i   (mode.hold),
    .run_i    (mode.run),
    .upd_evt_o(upd_evt),
    .uip_o    (uip_o)
  );

  rtc_per_div u_per (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tb_tick_i(tb_tick_i),
    .en_i     (per_en),
    .rate_i   (rate_i),
    .per_evt_o(per_evt)
  );

  rtc_flag_unit u_flg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .upd_evt_i(upd_evt),
    .per_evt_i(per_evt),
    .clr_i    (flag_clr_i),
    .uie_i    (uie_i),
    .pie_i    (pie_i),
    .flags_o  (flags_o),
    .irq_o    (irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) upd_tick_q <= 1'b0;
    else         upd_tick_q <= upd_evt && mode.run;
  end

  assign upd_tick_o = upd_tick_q;
endmodule

// File: rtl/rtc_tick_core_chk.sv
module rtc_tick_core_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [2:0] div_ctl_i,
  input logic       set_mode_i,
  input logic       upd_tick_o,
  input logic       uip_o,
  input logic [7:0] flags_o
);
  assert_tick_sets_uf_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_tick_o |-> flags_o[4]);

  assert_no_uip_at_tick_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_tick_o |-> !uip_o);

  assert_hold_no_uip_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_ctl_i[2:1] == 2'b11) |-> !uip_o);

  assert_hold_no_tick_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_ctl_i[2:1] == 2'b11) |=> !upd_tick_o);

  assert_set_blocks_tick_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_mode_i |=> !upd_tick_o);

  assert_tick_one_cycle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_tick_o |=> !upd_tick_o);

  assert_irqf_has_source_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_o[7] |-> (flags_o[4] || flags_o[6]));
endmodule

bind rtc_tick_core rtc_tick_core_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .div_ctl_i (div_ctl_i),
  .set_mode_i(set_mode_i),
  .upd_tick_o(upd_tick_o),
  .uip_o     (uip_o),
  .flags_o   (flags_o)
);

// File: tb/rtc_tick_core_bench.sv
`timescale 1ns/1ps
module rtc_tick_core_bench;
  localparam int TPS = 1024;
  localparam int UIP = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [2:0] div = 3'b010;
  logic [3:0] rate = 4'd0;
  logic       pie = 1'b0, uie = 1'b0, setm = 1'b0, clr = 1'b0;
  logic       upd_tick, uip, irq;
  logic [7:0] flags;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  rtc_tick_core #(.TICK_HZ(TPS), .UIP_TICKS(UIP)) u_rtc_tick_core (
    .clk_i(clk), .rst_ni(rst_n), .tb_tick_i(tick), .div_ctl_i(div),
    .rate_i(rate), .pie_i(pie), .uie_i(uie), .set_mode_i(setm),
    .flag_clr_i(clr), .upd_tick_o(upd_tick), .uip_o(uip),
    .flags_o(flags), .irq_o(irq)
  );

  function automatic int exp_period(input logic [3:0] c);
    if (c == 4'd1) return 128;
    if (c == 4'd2) return 64;
    return 1 << (c - 1);
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%02h expected 0x%02h at %0t", req, act, exp, $time);
    end
  endtask

  // cycle model built from the requirements
  int  m_ph, m_pc;
  logic [3:0] m_rate;
  logic m_uf, m_pf, m_tick;
  bit  b_hold, b_run, b_upd, b_pen, b_pev;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph <= 0; m_pc <= 0; m_rate <= 4'd0;
      m_uf <= 1'b0; m_pf <= 1'b0; m_tick <= 1'b0;
    end else begin
      b_hold = (div[2:1] == 2'b11);
      b_run  = !setm && (div <= 3'd2);
      b_upd  = tick && !b_hold && (m_ph == TPS - 1);
      if (b_hold)     m_ph <= TPS / 2;
      else if (tick)  m_ph <= (m_ph == TPS - 1) ? 0 : m_ph + 1;
      b_pen = pie && (rate != 4'd0) && !b_hold;
      b_pev = 0;
      if (!b_pen || rate != m_rate) m_pc <= 0;
      else if (tick) begin
        if (m_pc == exp_period(rate) - 1) begin m_pc <= 0; b_pev = 1; end
        else m_pc <= m_pc + 1;
      end
      m_rate <= rate;
      m_uf   <= b_upd ? 1'b1 : (clr ? 1'b0 : m_uf);
      m_pf   <= b_pev ? 1'b1 : (clr ? 1'b0 : m_pf);
      m_tick <= b_upd && b_run;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      logic e_irqf, e_uip;
      e_irqf = (m_uf & uie) | (m_pf & pie);
      e_uip  = !setm && (div <= 3'd2) && (m_ph >= TPS - UIP);
      check("R3 uip window", {7'd0, uip}, {7'd0, e_uip});
      check("R2 R6 advance tick", {7'd0, upd_tick}, {7'd0, m_tick});
      check("R2 R10 UF", {7'd0, flags[4]}, {7'd0, m_uf});
      check("R7 R8 R10 PF", {7'd0, flags[6]}, {7'd0, m_pf});
      check("R9 IRQF", {7'd0, flags[7]}, {7'd0, e_irqf});
      check("R9 irq line", {7'd0, irq}, {7'd0, e_irqf});
      check("R10 reserved bits", {flags[5], flags[3:0]}, 8'd0);
      if (div[2:1] == 2'b11) check("R4 hold uip", {7'd0, uip}, 8'd0);
    end
  end

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1 reset flags", flags, 8'd0);
    check("R1 reset tick", {6'd0, upd_tick, irq}, 8'd0);
    check("R1 reset uip", {7'd0, uip}, 8'd0);
    #1 rst_n = 1'b1;
    step();
    check("R1 after reset", {flags[7:1], upd_tick}, 8'd0);

    // directed: steady run, fast periodic rate, interrupts enabled
    tick = 1'b1; rate = 4'd3; pie = 1'b1; uie = 1'b1;
    repeat (TPS + 20) step();

    // random segments
    for (int seg = 0; seg < 40; seg++) begin
      int n;
      rate = 4'($urandom % 7);
      pie  = ($urandom % 4) != 0;
      uie  = $urandom % 2;
      setm = ($urandom % 6) == 0;
      div  = (($urandom % 8) == 0) ? 3'b110 :
             ((($urandom % 8) == 0) ? 3'b011 : 3'b010);
      n = 500 + int'($urandom % 1500);
      for (int i = 0; i < n; i++) begin
        tick = ($urandom % 8) != 0;
        clr  = ($urandom % 64) == 0;
        if (($urandom % 700) == 0) rate = 4'($urandom % 7);
        step();
      end
      clr = 1'b0;
    end

    // directed R5: half-second delay after release from hold
    setm = 1'b0; tick = 1'b1; div = 3'b110;
    repeat (5) step();
    check("R4 hold tick", {7'd0, upd_tick}, 8'd0);
    div = 3'b010;
    begin
      int cnt;
      cnt = 0;
      do begin
        @(negedge clk);
        cnt++;
      end while (!upd_tick && cnt < TPS);
      #1;
      check("R5 first update delay", 8'(cnt >> 2), 8'((TPS / 2) >> 2));
      check("R5 first update delay low bits", 8'(cnt & 3), 8'((TPS / 2) & 3));
    end
    step();
    check("R6 tick one cycle", {7'd0, upd_tick}, 8'd0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule